// File: doc/BRIEF.md
# Cross-processor control and mailbox registers

This block connects a host CPU to a coprocessor CPU through two small byte-wide register files, one on each side. The host writes a control byte that can interrupt the coprocessor, send it a non-maskable interrupt, stall it, or hold it in reset, and that carries a 4-bit message. The coprocessor writes a control byte that can interrupt the host, choose where the host's interrupt vectors come from, and carry a 4-bit message back.

Each interrupt request is latched as a pending bit until the receiving side writes a clear. The receiving side also has an enable that gates the pending bit onto its interrupt line. The host also loads the coprocessor's start, NMI and IRQ vectors. The coprocessor loads two override vectors that can stand in for the host's ROM vector bytes when the host fetches its IRQ or NMI vector. When the host drops the reset hold, the block gives a one-cycle release strobe so that the coprocessor core can begin at its start vector.

Both register ports decode writes on the clock edge. Reads are combinational on the current address.

Top module: `xcm_mailbox`

## Requirements
- R1: After reset, cop_rst_o and cop_halt_o are 1. cop_irq_o, cop_nmi_o, host_irq_o and cop_release_o are 0. All vector outputs are 0, and both status reads at offset 0 return 0.
- R2: A host write to offset 0 with bit 7 set makes the coprocessor IRQ pending. The pending bit shows at coprocessor read offset 0 bit 7. cop_irq_o is the pending bit ANDed with the coprocessor enable (coprocessor offset 1, bit 7). The pending bit stays set until the coprocessor writes offset 2 with bit 7 set.
- R3: A host write to offset 0 with bit 4 set makes the coprocessor NMI pending. The pending bit shows at coprocessor read offset 0 bit 4. cop_nmi_o is the pending bit ANDed with coprocessor offset 1 bit 4. The pending bit stays set until the coprocessor writes offset 2 with bit 4 set.
- R4: Host offset 0 bit 6 is the wait request and bit 5 is the reset hold. From the cycle after the write, cop_rst_o equals bit 5 and cop_halt_o equals bit 6 OR bit 5.
- R5: A host write to offset 0 that changes the reset hold from 1 to 0 drives cop_release_o high for exactly the one cycle after that write. No other write drives it high.
- R6: Bits 3:0 of a host offset-0 write appear at coprocessor read offset 0 bits 3:0. Bits 3:0 of a coprocessor offset-0 write appear at host read offset 0 bits 3:0.
- R7: A coprocessor write to offset 0 with bit 7 set makes the host IRQ pending, shown at host read offset 0 bit 7. host_irq_o is the pending bit ANDed with the host enable (host offset 1, bit 7). The pending bit stays set until the host writes offset 2 with bit 7 set. Coprocessor bits 6 (IRQ vector select) and 4 (NMI vector select) read back at host offset 0 bits 6 and 4.
- R8: Host offsets 3/4, 5/6 and 7/8 load the low/high bytes of cop_rst_vec_o, cop_nmi_vec_o and cop_irq_vec_o. Coprocessor offsets 3/4 and 5/6 load the low/high bytes of the host IRQ and NMI override vectors. Each byte is written on its own and is visible in the next cycle.
- R9: h_vf_data equals h_rom_data except in two cases. During an IRQ fetch (h_vf_irq) with the IRQ select set, it is the override byte chosen by h_vf_hi (0 = low, 1 = high). During an NMI fetch (h_vf_nmi) with the NMI select set, it is the NMI override byte chosen the same way. An IRQ fetch takes priority over an NMI fetch.
- R10: When a set and a clear of the same pending bit happen in the same cycle, the set wins.
- R11: Writes to offsets outside the map (host 9..15, coprocessor 7..15) change nothing. Reads at any offset other than 0 return 0 on both ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_we | input | 1 | Host register write strobe |
| h_addr | input | ADDR_W | Host register offset |
| h_wdata | input | DATA_W | Host write data |
| h_rdata | output | DATA_W | Host read data (status at offset 0) |
| c_we | input | 1 | Coprocessor register write strobe |
| c_addr | input | ADDR_W | Coprocessor register offset |
| c_wdata | input | DATA_W | Coprocessor write data |
| c_rdata | output | DATA_W | Coprocessor read data (status at offset 0) |
| cop_irq_o | output | 1 | IRQ line to the coprocessor |
| cop_nmi_o | output | 1 | NMI line to the coprocessor |
| cop_rst_o | output | 1 | Reset hold to the coprocessor |
| cop_halt_o | output | 1 | Coprocessor stalled (wait or reset) |
| cop_release_o | output | 1 | One-cycle strobe when the reset hold is dropped |
| cop_rst_vec_o | output | VEC_W | Coprocessor start vector |
| cop_nmi_vec_o | output | VEC_W | Coprocessor NMI vector |
| cop_irq_vec_o | output | VEC_W | Coprocessor IRQ vector |
| host_irq_o | output | 1 | IRQ line to the host |
| h_vf_irq | input | 1 | Host is fetching its IRQ vector |
| h_vf_nmi | input | 1 | Host is fetching its NMI vector |
| h_vf_hi | input | 1 | Vector fetch byte select (0 low, 1 high) |
| h_rom_data | input | DATA_W | Byte from ROM on the host data path |
| h_vf_data | output | DATA_W | Byte delivered to the host |

## Verification
The bench sweeps all 256 host control bytes and all 256 coprocessor control bytes, with periodic clears mixed in. This catches a design that swaps the halt and reset bits, one that lets the wait bit alone raise the release strobe, or one whose message nibble is shifted, since each would show a wrong status byte or line state on some value. The bench also sets and clears the same pending bit in one cycle on both sides: a clear-priority design would drop an interrupt there. For every select, fetch kind and byte lane, it checks that the fetch mux returns the override byte only for the matching selected fetch. It also checks that vector bytes load independently and that writes to unmapped offsets leave every output unchanged. An off-by-one decode would corrupt a neighbouring vector or let a stray write through.

// File: rtl/xcm_pkg.sv
package xcm_pkg;
   // message nibble width carried in bits 3:0 of each control byte
   localparam int MSG_W = 4;

   // host-written control byte, bit positions decoded by the coprocessor side
   localparam int CT_IRQ  = 7;
   localparam int CT_WAIT = 6;
   localparam int CT_RST  = 5;
   localparam int CT_NMI  = 4;

   // coprocessor-written control byte, bit positions decoded by the host side
   localparam int SC_IRQ   = 7;
   localparam int SC_IVSEL = 6;
   localparam int SC_NVSEL = 4;

   // register offsets shared by both ports
   localparam int OFS_CTRL = 0;
   localparam int OFS_EN   = 1;
   localparam int OFS_CLR  = 2;
   localparam int OFS_VEC  = 3;

   // vector counts held on each side
   localparam int COP_VEC_N  = 3;
   localparam int HOST_VEC_N = 2;

   typedef struct packed {
      logic irq_pend;
      logic wait_req;
      logic rst_hold;
      logic nmi_pend;
   } h2c_flags_t;
endpackage

// File: rtl/xcm_h2c_ctrl.sv
module xcm_h2c_ctrl
   import xcm_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctrl_we,
   input  logic             req_irq,
   input  logic             req_wait,
   input  logic             req_rst,
   input  logic             req_nmi,
   input  logic [MSG_W-1:0] msg_in,
   input  logic             en_we,
   input  logic             en_irq,
   input  logic             en_nmi,
   input  logic             clr_irq,
   input  logic             clr_nmi,
   output logic [MSG_W-1:0] msg_out,
   output logic             irq_pend,
   output logic             nmi_pend,
   output logic             cop_irq,
   output logic             cop_nmi,
   output logic             rst_hold,
   output logic             halted,
   output logic             release_pulse
);
   h2c_flags_t       flags;
   logic             irq_en;
   logic             nmi_en;
   logic [MSG_W-1:0] msg_q;
   logic             rel_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags    <= '{irq_pend: 1'b0, wait_req: 1'b0, rst_hold: 1'b1, nmi_pend: 1'b0};
         msg_q    <= '0;
         irq_en   <= 1'b0;
         nmi_en   <= 1'b0;
         rel_q    <= 1'b0;
      end else begin
         rel_q <= ctrl_we && flags.rst_hold && !req_rst;
         if (ctrl_we) begin
            flags.wait_req <= req_wait;
            flags.rst_hold <= req_rst;
            msg_q          <= msg_in;
         end
         // a set in the same cycle as a clear takes priority
         if (ctrl_we && req_irq)
            flags.irq_pend <= 1'b1;
         else if (clr_irq)
            flags.irq_pend <= 1'b0;
         if (ctrl_we && req_nmi)
            flags.nmi_pend <= 1'b1;
         else if (clr_nmi)
            flags.nmi_pend <= 1'b0;
         if (en_we) begin
            irq_en <= en_irq;
            nmi_en <= en_nmi;
         end
      end
   end

   assign msg_out       = msg_q;
   assign irq_pend      = flags.irq_pend;
   assign nmi_pend      = flags.nmi_pend;
   assign cop_irq       = flags.irq_pend && irq_en;
   assign cop_nmi       = flags.nmi_pend && nmi_en;
   assign rst_hold      = flags.rst_hold;
   assign halted        = flags.rst_hold || flags.wait_req;
   assign release_pulse = rel_q;
endmodule

// File: rtl/xcm_c2h_ctrl.sv
module xcm_c2h_ctrl
   import xcm_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctrl_we,
   input  logic             raise,
   input  logic             ivsel_in,
   input  logic             nvsel_in,
   input  logic [MSG_W-1:0] msg_in,
   input  logic             en_we,
   input  logic             en_bit,
   input  logic             clr,
   output logic [MSG_W-1:0] msg_out,
   output logic             pend,
   output logic             ivsel,
   output logic             nvsel,
   output logic             host_irq
);
   logic             pend_q;
   logic             en_q;
   logic             ivsel_q;
   logic             nvsel_q;
   logic [MSG_W-1:0] msg_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q  <= 1'b0;
         en_q    <= 1'b0;
         ivsel_q <= 1'b0;
         nvsel_q <= 1'b0;
         msg_q   <= '0;
      end else begin
         if (ctrl_we) begin
            ivsel_q <= ivsel_in;
            nvsel_q <= nvsel_in;
            msg_q   <= msg_in;
         end
         if (ctrl_we && raise)
            pend_q <= 1'b1;
         else if (clr)
            pend_q <= 1'b0;
         if (en_we)
            en_q <= en_bit;
      end
   end

   assign msg_out  = msg_q;
   assign pend     = pend_q;
   assign ivsel    = ivsel_q;
   assign nvsel    = nvsel_q;
   assign host_irq = pend_q && en_q;
endmodule

// File: rtl/xcm_vec_bank.sv
module xcm_vec_bank #(
   parameter int DATA_W = 8,
   parameter int VEC_W  = 16,
   parameter int NUM    = 2,
   parameter int ADDR_W = 4,
   parameter int BASE   = 3
)(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we,
   input  logic [ADDR_W-1:0]          addr,
   input  logic [DATA_W-1:0]          wdata,
   output logic [NUM-1:0][VEC_W-1:0]  vec
);
   localparam int VB = VEC_W / DATA_W;

   if (VB * DATA_W != VEC_W) begin : g_bad_split
      $error("vector width must be a whole number of data bytes");
   end
   if (BASE + NUM * VB > (1 << ADDR_W)) begin : g_bad_span
      $error("vector bank does not fit in the address space");
   end

   for (genvar i = 0; i < NUM; i++) begin : g_vec
      for (genvar b = 0; b < VB; b++) begin : g_byte
         localparam logic [ADDR_W-1:0] SLOT = ADDR_W'(BASE + i * VB + b);
         logic [DATA_W-1:0] byte_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               byte_q <= '0;
            else if (we && (addr == SLOT))
               byte_q <= wdata;
         end
         assign vec[i][b*DATA_W +: DATA_W] = byte_q;
      end
   end
endmodule

// File: rtl/xcm_vec_mux.sv
module xcm_vec_mux #(
   parameter int DATA_W = 8,
   parameter int VEC_W  = 16
)(
   input  logic              fetch_irq,
   input  logic              fetch_nmi,
   input  logic              hi,
   input  logic              irq_sel,
   input  logic              nmi_sel,
   input  logic [VEC_W-1:0]  irq_ovr,
   input  logic [VEC_W-1:0]  nmi_ovr,
   input  logic [DATA_W-1:0] rom_data,
   output logic [DATA_W-1:0] data_out
);
   logic [DATA_W-1:0] irq_byte;
   logic [DATA_W-1:0] nmi_byte;

   assign irq_byte = hi ? irq_ovr[DATA_W +: DATA_W] : irq_ovr[0 +: DATA_W];
   assign nmi_byte = hi ? nmi_ovr[DATA_W +: DATA_W] : nmi_ovr[0 +: DATA_W];

   always_comb begin
      data_out = rom_data;
      if (fetch_irq) begin
         if (irq_sel)
            data_out = irq_byte;
      end else if (fetch_nmi) begin
         if (nmi_sel)
            data_out = nmi_byte;
      end
   end
endmodule

// File: rtl/xcm_mailbox.sv
module xcm_mailbox
   import xcm_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int VEC_W  = 16,
   parameter int ADDR_W = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              h_we,
   input  logic [ADDR_W-1:0] h_addr,
   input  logic [DATA_W-1:0] h_wdata,
   output logic [DATA_W-1:0] h_rdata,
   input  logic              c_we,
   input  logic [ADDR_W-1:0] c_addr,
   input  logic [DATA_W-1:0] c_wdata,
   output logic [DATA_W-1:0] c_rdata,
   output logic              cop_irq_o,
   output logic              cop_nmi_o,
   output logic              cop_rst_o,
   output logic              cop_halt_o,
   output logic              cop_release_o,
   output logic [VEC_W-1:0]  cop_rst_vec_o,
   output logic [VEC_W-1:0]  cop_nmi_vec_o,
   output logic [VEC_W-1:0]  cop_irq_vec_o,
   output logic              host_irq_o,
   input  logic              h_vf_irq,
   input  logic              h_vf_nmi,
   input  logic              h_vf_hi,
   input  logic [DATA_W-1:0] h_rom_data,
   output logic [DATA_W-1:0] h_vf_data
);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_EN);
   localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);

   if (DATA_W != 8) begin : g_bad_data
      $error("control byte layout needs DATA_W of 8");
   end
   if (VEC_W != 2 * DATA_W) begin : g_bad_vec
      $error("vectors must be two data bytes wide");
   end
   if (OFS_VEC + 2 * COP_VEC_N > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end

   logic h_ctrl_we, h_en_we, h_clr_we;
   logic c_ctrl_we, c_en_we, c_clr_we;

   assign h_ctrl_we = h_we && (h_addr == A_CTRL);
   assign h_en_we   = h_we && (h_addr == A_EN);
   assign h_clr_we  = h_we && (h_addr == A_CLR);
   assign c_ctrl_we = c_we && (c_addr == A_CTRL);
   assign c_en_we   = c_we && (c_addr == A_EN);
   assign c_clr_we  = c_we && (c_addr == A_CLR);

   logic [MSG_W-1:0] h2c_msg, c2h_msg;
   logic             cop_irq_pend, cop_nmi_pend;
   logic             host_pend, ivsel, nvsel;

   xcm_h2c_ctrl u_h2c (
      .clk           (clk),
      .rst_n         (rst_n),
      .ctrl_we       (h_ctrl_we),
      .req_irq       (h_wdata[CT_IRQ]),
      .req_wait      (h_wdata[CT_WAIT]),
      .req_rst       (h_wdata[CT_RST]),
      .req_nmi       (h_wdata[CT_NMI]),
      .msg_in        (h_wdata[MSG_W-1:0]),
      .en_we         (c_en_we),
      .en_irq        (c_wdata[CT_IRQ]),
      .en_nmi        (c_wdata[CT_NMI]),
      .clr_irq       (c_clr_we && c_wdata[CT_IRQ]),
      .clr_nmi       (c_clr_we && c_wdata[CT_NMI]),
      .msg_out       (h2c_msg),
      .irq_pend      (cop_irq_pend),
      .nmi_pend      (cop_nmi_pend),
      .cop_irq       (cop_irq_o),
      .cop_nmi       (cop_nmi_o),
      .rst_hold      (cop_rst_o),
      .halted        (cop_halt_o),
      .release_pulse (cop_release_o)
   );

   xcm_c2h_ctrl u_c2h (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctrl_we  (c_ctrl_we),
      .raise    (c_wdata[SC_IRQ]),
      .ivsel_in (c_wdata[SC_IVSEL]),
      .nvsel_in (c_wdata[SC_NVSEL]),
      .msg_in   (c_wdata[MSG_W-1:0]),
      .en_we    (h_en_we),
      .en_bit   (h_wdata[SC_IRQ]),
      .clr      (h_clr_we && h_wdata[SC_IRQ]),
      .msg_out  (c2h_msg),
      .pend     (host_pend),
      .ivsel    (ivsel),
      .nvsel    (nvsel),
      .host_irq (host_irq_o)
   );

   logic [COP_VEC_N-1:0][VEC_W-1:0]  cop_vecs;
   logic [HOST_VEC_N-1:0][VEC_W-1:0] host_ovr;

   xcm_vec_bank #(
      .DATA_W (DATA_W), .VEC_W (VEC_W), .NUM (COP_VEC_N),
      .ADDR_W (ADDR_W), .BASE (OFS_VEC)
   ) u_cop_vecs (
      .clk (clk), .rst_n (rst_n), .we (h_we), .addr (h_addr),
      .wdata (h_wdata), .vec (cop_vecs)
   );

   xcm_vec_bank #(
      .DATA_W (DATA_W), .VEC_W (VEC_W), .NUM (HOST_VEC_N),
      .ADDR_W (ADDR_W), .BASE (OFS_VEC)
   ) u_host_ovr (
      .clk (clk), .rst_n (rst_n), .we (c_we), .addr (c_addr),
      .wdata (c_wdata), .vec (host_ovr)
   );

   assign cop_rst_vec_o = cop_vecs[0];
   assign cop_nmi_vec_o = cop_vecs[1];
   assign cop_irq_vec_o = cop_vecs[2];

   xcm_vec_mux #(.DATA_W (DATA_W), .VEC_W (VEC_W)) u_vmux (
      .fetch_irq (h_vf_irq),
      .fetch_nmi (h_vf_nmi),
      .hi        (h_vf_hi),
      .irq_sel   (ivsel),
      .nmi_sel   (nvsel),
      .irq_ovr   (host_ovr[0]),
      .nmi_ovr   (host_ovr[1]),
      .rom_data  (h_rom_data),
      .data_out  (h_vf_data)
   );

   always_comb begin
      h_rdata = '0;
      if (h_addr == A_CTRL) begin
         h_rdata[SC_IRQ]    = host_pend;
         h_rdata[SC_IVSEL]  = ivsel;
         h_rdata[SC_NVSEL]  = nvsel;
         h_rdata[MSG_W-1:0] = c2h_msg;
      end
   end

   always_comb begin
      c_rdata = '0;
      if (c_addr == A_CTRL) begin
         c_rdata[CT_IRQ]    = cop_irq_pend;
         c_rdata[CT_NMI]    = cop_nmi_pend;
         c_rdata[MSG_W-1:0] = h2c_msg;
      end
   end
endmodule

// File: rtl/xcm_mailbox_chk.sv
module xcm_mailbox_chk #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 4
)(
   input logic              clk,
   input logic              rst_n,
   input logic              h_we,
   input logic [ADDR_W-1:0] h_addr,
   input logic              h_wait_bit,
   input logic              h_rst_bit,
   input logic              c_we,
   input logic [ADDR_W-1:0] c_addr,
   input logic              cop_irq_o,
   input logic              cop_nmi_o,
   input logic              cop_rst_o,
   input logic              cop_halt_o,
   input logic              cop_release_o,
   input logic              host_irq_o,
   input logic              h_vf_irq,
   input logic              h_vf_nmi,
   input logic [DATA_W-1:0] h_rom_data,
   input logic [DATA_W-1:0] h_vf_data
);
   localparam logic [ADDR_W-1:0] K_CTRL = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] K_EN   = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] K_CLR  = ADDR_W'(2);

   // R4
   halt_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (h_we && h_addr == K_CTRL) |=> (cop_halt_o == ($past(h_wait_bit) || $past(h_rst_bit))));

   // R4
   rst_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (h_we && h_addr == K_CTRL) |=> (cop_rst_o == $past(h_rst_bit)));

   // R5
   release_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cop_release_o |-> (!cop_rst_o && $past(cop_rst_o)));

   // R5
   release_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cop_release_o |=> !cop_release_o);

   // R2
   cop_irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cop_irq_o) && !$past(c_we && (c_addr == K_EN || c_addr == K_CLR))) |-> cop_irq_o);

   // R3
   cop_nmi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cop_nmi_o) && !$past(c_we && (c_addr == K_EN || c_addr == K_CLR))) |-> cop_nmi_o);

   // R7
   host_irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(host_irq_o) && !$past(h_we && (h_addr == K_EN || h_addr == K_CLR))) |-> host_irq_o);

   // R9
   rom_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!h_vf_irq && !h_vf_nmi) |-> (h_vf_data == h_rom_data));
endmodule

bind xcm_mailbox xcm_mailbox_chk #(.DATA_W (DATA_W), .ADDR_W (ADDR_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .h_we          (h_we),
   .h_addr        (h_addr),
   .h_wait_bit    (h_wdata[6]),
   .h_rst_bit     (h_wdata[5]),
   .c_we          (c_we),
   .c_addr        (c_addr),
   .cop_irq_o     (cop_irq_o),
   .cop_nmi_o     (cop_nmi_o),
   .cop_rst_o     (cop_rst_o),
   .cop_halt_o    (cop_halt_o),
   .cop_release_o (cop_release_o),
   .host_irq_o    (host_irq_o),
   .h_vf_irq      (h_vf_irq),
   .h_vf_nmi      (h_vf_nmi),
   .h_rom_data    (h_rom_data),
   .h_vf_data     (h_vf_data)
);

// File: tb/xcm_mailbox_test.sv
`timescale 1ns/1ps
module xcm_mailbox_test;
   localparam int DW = 8;
   localparam int VW = 16;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          h_we = 1'b0, c_we = 1'b0;
   logic [AW-1:0] h_addr = '0, c_addr = '0;
   logic [DW-1:0] h_wdata = '0, c_wdata = '0;
   logic [DW-1:0] h_rdata, c_rdata;
   logic          cop_irq_o, cop_nmi_o, cop_rst_o, cop_halt_o, cop_release_o, host_irq_o;
   logic [VW-1:0] cop_rst_vec_o, cop_nmi_vec_o, cop_irq_vec_o;
   logic          h_vf_irq = 1'b0, h_vf_nmi = 1'b0, h_vf_hi = 1'b0;
   logic [DW-1:0] h_rom_data = '0;
   logic [DW-1:0] h_vf_data;

   int tests = 0;
   int fails = 0;

   always #2 clk = ~clk;

   xcm_mailbox uut (
      .clk (clk), .rst_n (rst_n),
      .h_we (h_we), .h_addr (h_addr), .h_wdata (h_wdata), .h_rdata (h_rdata),
      .c_we (c_we), .c_addr (c_addr), .c_wdata (c_wdata), .c_rdata (c_rdata),
      .cop_irq_o (cop_irq_o), .cop_nmi_o (cop_nmi_o), .cop_rst_o (cop_rst_o),
      .cop_halt_o (cop_halt_o), .cop_release_o (cop_release_o),
      .cop_rst_vec_o (cop_rst_vec_o), .cop_nmi_vec_o (cop_nmi_vec_o),
      .cop_irq_vec_o (cop_irq_vec_o), .host_irq_o (host_irq_o),
      .h_vf_irq (h_vf_irq), .h_vf_nmi (h_vf_nmi), .h_vf_hi (h_vf_hi),
      .h_rom_data (h_rom_data), .h_vf_data (h_vf_data)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   task automatic hwr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      h_we = 1'b1; h_addr = a; h_wdata = d;
      @(negedge clk);
      h_we = 1'b0;
      #1;
   endtask

   task automatic cwr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      c_we = 1'b1; c_addr = a; c_wdata = d;
      @(negedge clk);
      c_we = 1'b0;
      #1;
   endtask

   task automatic both(input logic [AW-1:0] ha, input logic [DW-1:0] hd,
                       input logic [AW-1:0] ca, input logic [DW-1:0] cd);
      @(negedge clk);
      h_we = 1'b1; h_addr = ha; h_wdata = hd;
      c_we = 1'b1; c_addr = ca; c_wdata = cd;
      @(negedge clk);
      h_we = 1'b0; c_we = 1'b0;
      #1;
   endtask

   task automatic hrd(input logic [AW-1:0] a, output logic [DW-1:0] d);
      h_addr = a;
      #1;
      d = h_rdata;
   endtask

   task automatic crd(input logic [AW-1:0] a, output logic [DW-1:0] d);
      c_addr = a;
      #1;
      d = c_rdata;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [DW-1:0] rd;
      logic          prev_rst, pi, pn, ph;
      logic [VW-1:0] vexp [3];
      logic [VW-1:0] oirq, onmi;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;

      // R1 reset state
      chk("R1 cop_rst", cop_rst_o, 1);
      chk("R1 cop_halt", cop_halt_o, 1);
      chk("R1 cop_irq", cop_irq_o, 0);
      chk("R1 cop_nmi", cop_nmi_o, 0);
      chk("R1 host_irq", host_irq_o, 0);
      chk("R1 release", cop_release_o, 0);
      chk("R1 vectors", {cop_rst_vec_o, cop_nmi_vec_o}, 0);
      chk("R1 irq vector", cop_irq_vec_o, 0);
      hrd(0, rd); chk("R1 host status", rd, 0);
      crd(0, rd); chk("R1 cop status", rd, 0);

      // sweep every host control byte: R2 R3 R4 R5 R6
      cwr(1, 8'h90);
      prev_rst = 1'b1; pi = 1'b0; pn = 1'b0;
      for (int v = 0; v < 256; v++) begin
         logic [7:0] d;
         d = 8'(v);
         hwr(0, d);
         pi = pi | d[7];
         pn = pn | d[4];
         chk("R4 cop_rst", cop_rst_o, d[5]);
         chk("R4 cop_halt", cop_halt_o, d[6] | d[5]);
         chk("R5 release", cop_release_o, prev_rst & ~d[5]);
         chk("R2 cop_irq", cop_irq_o, pi);
         chk("R3 cop_nmi", cop_nmi_o, pn);
         crd(0, rd);
         chk("R6 cop status", rd, {pi, 2'b00, pn, d[3:0]});
         tick();
         chk("R5 release single cycle", cop_release_o, 0);
         prev_rst = d[5];
         if ((v % 4) == 3) begin
            cwr(2, 8'h90);
            pi = 1'b0; pn = 1'b0;
            chk("R2 irq cleared", cop_irq_o, 0);
            chk("R3 nmi cleared", cop_nmi_o, 0);
         end
      end

      // R2 R3 enable gating and selective clear
      hwr(0, 8'h90);
      cwr(1, 8'h00);
      chk("R2 gated irq", cop_irq_o, 0);
      chk("R3 gated nmi", cop_nmi_o, 0);
      crd(0, rd); chk("R2 pending under gate", rd, 8'h90);
      cwr(1, 8'h80);
      chk("R2 enabled irq", cop_irq_o, 1);
      chk("R3 nmi still gated", cop_nmi_o, 0);
      cwr(2, 8'h10);
      crd(0, rd); chk("R3 only nmi cleared", rd, 8'h80);
      cwr(2, 8'h80);
      crd(0, rd); chk("R2 irq cleared", rd, 8'h00);

      // sweep every coprocessor control byte: R6 R7
      hwr(1, 8'h80);
      ph = 1'b0;
      for (int v = 0; v < 256; v++) begin
         logic [7:0] d;
         d = 8'(v);
         cwr(0, d);
         ph = ph | d[7];
         chk("R7 host_irq", host_irq_o, ph);
         hrd(0, rd);
         chk("R7 host status", rd, {ph, d[6], 1'b0, d[4], d[3:0]});
         if ((v % 3) == 2) begin
            hwr(2, 8'h80);
            ph = 1'b0;
            chk("R7 host irq cleared", host_irq_o, 0);
         end
      end
      cwr(0, 8'h80);
      hwr(1, 8'h00);
      chk("R7 host gate off", host_irq_o, 0);
      hrd(0, rd); chk("R7 pending kept", rd[7], 1);
      hwr(1, 8'h80);
      chk("R7 host gate on", host_irq_o, 1);
      hwr(2, 8'h80);

      // R10 set beats clear in the same cycle, both directions
      cwr(1, 8'h90);
      both(0, 8'h90, 2, 8'h90);
      chk("R10 cop irq set wins", cop_irq_o, 1);
      chk("R10 cop nmi set wins", cop_nmi_o, 1);
      both(2, 8'h80, 0, 8'h80);
      chk("R10 host set wins", host_irq_o, 1);
      hwr(2, 8'h80);
      cwr(2, 8'h90);

      // R8 vector loading, byte by byte
      for (int k = 0; k < 16; k++) begin
         for (int i = 0; i < 3; i++) begin
            vexp[i] = 16'(k * 16'h1357 + i * 16'h0f0f + 16'h0101);
            hwr(AW'(3 + 2 * i), vexp[i][7:0]);
            hwr(AW'(4 + 2 * i), vexp[i][15:8]);
         end
         chk("R8 start vector", cop_rst_vec_o, vexp[0]);
         chk("R8 nmi vector", cop_nmi_vec_o, vexp[1]);
         chk("R8 irq vector", cop_irq_vec_o, vexp[2]);
      end
      hwr(3, 8'h5A);
      chk("R8 low byte alone", cop_rst_vec_o, {vexp[0][15:8], 8'h5A});
      hwr(8, 8'hC3);
      chk("R8 high byte alone", cop_irq_vec_o, {8'hC3, vexp[2][7:0]});
      vexp[0] = {vexp[0][15:8], 8'h5A};
      vexp[2] = {8'hC3, vexp[2][7:0]};

      // R9 fetch mux over select, fetch kind, byte lane and ROM data
      oirq = 16'hBEEF; onmi = 16'hCAFE;
      cwr(3, oirq[7:0]); cwr(4, oirq[15:8]);
      cwr(5, onmi[7:0]); cwr(6, onmi[15:8]);
      for (int s = 0; s < 4; s++) begin
         logic is, ns;
         is = s[0]; ns = s[1];
         cwr(0, {1'b0, is, 1'b0, ns, 4'h0});
         for (int kind = 0; kind < 4; kind++) begin
            for (int hi = 0; hi < 2; hi++) begin
               for (int r = 0; r < 4; r++) begin
                  logic [7:0] rom, ex;
                  rom = 8'(r * 8'h55 + 8'h0C);
                  h_vf_irq = kind[0]; h_vf_nmi = kind[1]; h_vf_hi = hi[0]; h_rom_data = rom;
                  #1;
                  if (kind[0])
                     ex = is ? (hi[0] ? oirq[15:8] : oirq[7:0]) : rom;
                  else if (kind[1])
                     ex = ns ? (hi[0] ? onmi[15:8] : onmi[7:0]) : rom;
                  else
                     ex = rom;
                  chk("R9 fetch byte", h_vf_data, ex);
               end
            end
         end
      end
      h_vf_irq = 1'b0; h_vf_nmi = 1'b0;

      // R11 unmapped offsets
      cwr(0, 8'h50);
      for (int a = 9; a < 16; a++) begin
         hwr(AW'(a), 8'hFF);
         hrd(AW'(a), rd);
         chk("R11 host unmapped read", rd, 0);
      end
      chk("R11 vectors intact", cop_rst_vec_o, vexp[0]);
      chk("R11 irq vector intact", cop_irq_vec_o, vexp[2]);
      chk("R11 cop lines intact", {cop_irq_o, cop_nmi_o}, 0);
      for (int a = 7; a < 16; a++) begin
         cwr(AW'(a), 8'hFF);
         crd(AW'(a), rd);
         chk("R11 cop unmapped read", rd, 0);
      end
      hrd(1, rd); chk("R11 host offset 1 reads zero", rd, 0);
      chk("R11 host irq intact", host_irq_o, 0);
      h_vf_irq = 1'b1; h_vf_hi = 1'b1; #1;
      chk("R11 override intact", h_vf_data, oirq[15:8]);
      h_vf_irq = 1'b0;

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule